// File: doc/BRIEF.md
# Multi-Mode Timer and Event Counter

This block is a peripheral up-counter with a reload value, a small control register and a sticky overflow flag. A mode field selects what advances the counter. It can count edges of an external input, count ticks from one of two internal tick sources, or time a single external pulse using the internal ticks. When the counter passes all-ones it takes the reload value again, raises the overflow flag and toggles a divide-by-two output.

Software configures the block through a simple write port with three addresses. Address 0 holds the reload value, address 1 holds the control byte, and address 2 controls the interrupt. The running count and the control byte are always visible on output ports. The external input is asynchronous. It passes through a two-stage synchronizer and an edge detector before it is used.

Top module: `tmr_evcnt`

## Requirements
- R1: After reset, `count`, `ctrl`, `irq_flag`, `irq` and `pfd_out` are all 0.
- R2: A write to address 0 always updates the reload value. While the run bit is 0, the same write also loads `count`. While the run bit is 1, `count` is left untouched, and the new reload value is first used at the next overflow.
- R3: The control byte at address 1 has these fields. Bits 2:0 always read 0. Bit 3 selects the edge: 0 means rising, 1 means falling. Bit 4 is the run bit. Bit 5 selects the source: 1 means `tick_sys`, 0 means `tick_rtc`. Bits 7:6 select the mode: 01 is event, 10 is timer, 11 is pulse, and 00 is idle. While the run bit is 0, or in mode 00, `count` holds its value.
- R4: In timer mode, `count` rises by one for each cycle in which the selected tick input is 1. The tick input that is not selected has no effect.
- R5: An increment from all-ones loads the reload value into `count`, sets `irq_flag` and toggles the divider state. This happens in every mode.
- R6: In event mode, each active edge of `ext_in` advances `count` once, after the input is synchronized. Edges of the other polarity are ignored.
- R7: Pulse mode works as follows. The measurement starts on an active edge. From that point, `count` advances on each selected tick while `ext_in` stays at the active level. On the return edge the run bit clears itself and `count` holds the result. Later pulses are ignored until the run bit is written to 1 again.
- R8: `irq_flag` stays at 1 until a write to address 2 with bit 1 set. If such a write and an overflow fall in the same cycle, the flag stays at 1.
- R9: `irq` equals `irq_flag` gated by the interrupt enable, which is bit 0 of the last write to address 2. With the enable at 0, `irq` is 0.
- R10: `pfd_out` shows the divider state, which toggles on each overflow, while `pfd_en` is 1. While `pfd_en` is 0, `pfd_out` is 0.
- R11: In event mode and timer mode, hardware never clears the run bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 = reload, 1 = control, 2 = interrupt |
| wr_data | input | W | Write data |
| tick_sys | input | 1 | Fast internal tick enable |
| tick_rtc | input | 1 | Slow internal tick enable |
| ext_in | input | 1 | Asynchronous external input |
| pfd_en | input | 1 | Divider output enable |
| count | output | W | Current counter value |
| ctrl | output | 8 | Control byte readback |
| irq_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Gated interrupt request |
| pfd_out | output | 1 | Divide-by-two overflow output |

## Verification
Two events can land in the same clock edge: an overflow and a software write. The bench provokes this by writing the flag-clear at address 2 in the very cycle in which a tick takes the counter past all-ones. The expected result is that the flag is still set while the count has already reloaded. The bench also writes a new reload value while the counter runs just below all-ones. It then checks that the count moves on unchanged and that the wrap lands on the new value. Timer-mode results are swept over several reload values and tick counts, with expected counts, flag states and divider parity computed arithmetically.

// File: rtl/tmr_evcnt.sv
module tmr_evcnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic         tick_sys,
  input  logic         tick_rtc,
  input  logic         ext_in,
  input  logic         pfd_en,
  output logic [W-1:0] count,
  output logic [7:0]   ctrl,
  output logic         irq_flag,
  output logic         irq,
  output logic         pfd_out
);
  localparam logic [W-1:0] ALL1 = '1;

  logic [W-1:0] pre_q;
  logic [1:0]   mode;
  logic         edge_fall, run, src_sys;
  logic         irq_en, tog, pw_busy;
  logic [2:0]   sy;
  logic         rise, fall, act_edge, end_edge, lvl, tick;
  logic         pw_arm, pw_end, inc, ovf;
  logic         wr_pre, wr_ctl, wr_irq;

  assign wr_pre = wr_en && wr_addr == 2'd0;
  assign wr_ctl = wr_en && wr_addr == 2'd1;
  assign wr_irq = wr_en && wr_addr == 2'd2;

  assign rise     = sy[1] & ~sy[2];
  assign fall     = ~sy[1] & sy[2];
  assign act_edge = edge_fall ? fall : rise;
  assign end_edge = edge_fall ? rise : fall;
  assign lvl      = sy[1] ^ edge_fall;
  assign tick     = src_sys ? tick_sys : tick_rtc;

  assign pw_arm = run && mode == 2'b11 && !pw_busy && act_edge;
  assign pw_end = pw_busy && end_edge;

  always_comb begin
    unique case (mode)
      2'b01:   inc = run & act_edge;
      2'b10:   inc = run & tick;
      2'b11:   inc = run & (pw_busy | pw_arm) & lvl & tick;
      default: inc = 1'b0;
    endcase
  end

  assign ovf = inc && count == ALL1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy        <= '0;
      pre_q     <= '0;
      count     <= '0;
      mode      <= '0;
      edge_fall <= 1'b0;
      run       <= 1'b0;
      src_sys   <= 1'b0;
      pw_busy   <= 1'b0;
      irq_flag  <= 1'b0;
      irq_en    <= 1'b0;
      tog       <= 1'b0;
    end else begin
      sy <= {sy[1:0], ext_in};

      if (wr_pre) pre_q <= wr_data;

      if (wr_pre && !run)  count <= wr_data;
      else if (inc)        count <= ovf ? pre_q : count + 1'b1;

      if (wr_ctl) begin
        mode      <= wr_data[7:6];
        src_sys   <= wr_data[5];
        run       <= wr_data[4];
        edge_fall <= wr_data[3];
        pw_busy   <= 1'b0;
      end else begin
        if (pw_arm) pw_busy <= 1'b1;
        if (pw_end) begin
          pw_busy <= 1'b0;
          run     <= 1'b0;
        end
      end

      if (ovf)                       irq_flag <= 1'b1;
      else if (wr_irq && wr_data[1]) irq_flag <= 1'b0;
      if (wr_irq) irq_en <= wr_data[0];

      if (ovf) tog <= ~tog;
    end
  end

  assign ctrl    = {mode, src_sys, run, edge_fall, 3'b000};
  assign irq     = irq_flag & irq_en;
  assign pfd_out = pfd_en & tog;
endmodule

module tmr_evcnt_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [1:0]   wr_addr,
  input logic [W-1:0] wr_data,
  input logic [W-1:0] count,
  input logic [W-1:0] pre_q,
  input logic [1:0]   mode,
  input logic         run,
  input logic         flag,
  input logic         tog,
  input logic         inc,
  input logic         pw_end
);
  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !(wr_en && wr_addr == 2'd2 && wr_data[1]) |=> flag);

  // R5
  ovf_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc && count == '1 && !(wr_en && wr_addr == 2'd0 && !run) |=> flag && count == $past(pre_q));

  // R3
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !(wr_en && wr_addr == 2'd0) |=> $stable(count));

  // R7
  pw_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pw_end && !(wr_en && wr_addr == 2'd1) |=> !run);

  // R11
  run_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && mode != 2'b11 && !(wr_en && wr_addr == 2'd1) |=> run);

  // R10
  pfd_tog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tog) |-> $past(inc && count == '1));
endmodule

bind tmr_evcnt tmr_evcnt_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .count(count), .pre_q(pre_q), .mode(mode), .run(run), .flag(irq_flag),
  .tog(tog), .inc(inc), .pw_end(pw_end)
);

// File: tb/test_tmr_evcnt.sv
`timescale 1ns/1ps
module test_tmr_evcnt;
  logic        clk = 0, rst_n = 0;
  logic        wr_en = 0, tick_sys = 0, tick_rtc = 0, ext_in = 0, pfd_en = 1;
  logic [1:0]  wr_addr = 0;
  logic [15:0] wr_data = 0;
  logic [15:0] count;
  logic [7:0]  ctrl;
  logic        irq_flag, irq, pfd_out;
  int checks = 0, failures = 0;
  logic exp_tog = 0;

  always #2 clk = ~clk;

  tmr_evcnt #(.W(16)) i_tmr_evcnt (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tick_sys(tick_sys), .tick_rtc(tick_rtc), .ext_in(ext_in), .pfd_en(pfd_en),
    .count(count), .ctrl(ctrl), .irq_flag(irq_flag), .irq(irq), .pfd_out(pfd_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic ticks(input int n, input logic s, input logic r);
    for (int i = 0; i < n; i++) begin
      tick_sys = s; tick_rtc = r;
      @(negedge clk);
      tick_sys = 0; tick_rtc = 0;
      @(negedge clk);
    end
  endtask

  task automatic pulse(input logic lvl, input int n);
    ext_in = lvl;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] pl [3];
    pl[0] = 16'hFFFA; pl[1] = 16'hFFFE; pl[2] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 count", count, 0);
    chk("R1 ctrl", ctrl, 0);
    chk("R1 flag", irq_flag, 0);
    chk("R1 irq", irq, 0);
    chk("R1 pfd", pfd_out, 0);

    // R4 R5 R9 R10 R11 timer sweep
    foreach (pl[k]) begin
      for (int n = 0; n <= 12; n++) begin
        logic [15:0] c;
        int ov;
        wr(1, 16'h0000);
        wr(2, 16'h0003);
        wr(0, pl[k]);
        chk("R2 load stopped", count, pl[k]);
        wr(1, 16'h00B0);
        ticks(n, 1, 0);
        ticks(2, 0, 1);
        c = pl[k]; ov = 0;
        for (int i = 0; i < n; i++) begin
          if (c == 16'hFFFF) begin c = pl[k]; ov++; exp_tog = ~exp_tog; end
          else c = c + 1;
        end
        chk("R4 timer count", count, c);
        chk("R5 flag", irq_flag, ov > 0);
        chk("R9 irq", irq, ov > 0);
        chk("R10 pfd", pfd_out, exp_tog);
        chk("R11 run kept", ctrl[4], 1);
      end
    end

    // R4 rtc source selected, sys ignored
    wr(1, 16'h0000);
    wr(0, 16'h0040);
    wr(1, 16'h0090);
    ticks(5, 0, 1);
    ticks(3, 1, 0);
    chk("R4 rtc source", count, 16'h0045);

    // R3 idle mode and unused bits
    wr(1, 16'h0037);
    chk("R3 readback", ctrl, 8'h30);
    ticks(4, 1, 1);
    chk("R3 idle mode hold", count, 16'h0045);
    wr(1, 16'h00A0);
    ticks(4, 1, 1);
    chk("R3 run off hold", count, 16'h0045);

    // R2 preload write while running
    wr(1, 16'h0000);
    wr(0, 16'hFFFD);
    wr(1, 16'h00B0);
    ticks(1, 1, 0);
    wr(0, 16'h1234);
    chk("R2 running keeps count", count, 16'hFFFE);
    ticks(1, 1, 0);
    chk("R2 continue", count, 16'hFFFF);
    ticks(1, 1, 0);
    exp_tog = ~exp_tog;
    chk("R2 new reload", count, 16'h1234);

    // R8 clear and overflow same cycle
    wr(1, 16'h0000);
    wr(2, 16'h0003);
    chk("R8 cleared", irq_flag, 0);
    wr(0, 16'hFFFF);
    wr(1, 16'h00B0);
    wr_en = 1; wr_addr = 2; wr_data = 16'h0003; tick_sys = 1;
    @(negedge clk);
    wr_en = 0; tick_sys = 0;
    exp_tog = ~exp_tog;
    chk("R8 overflow wins", irq_flag, 1);
    chk("R5 reload same cycle", count, 16'hFFFF);
    wr(2, 16'h0002);
    chk("R8 clear alone", irq_flag, 0);
    ticks(1, 1, 0);
    exp_tog = ~exp_tog;
    chk("R9 flag set disabled", irq_flag, 1);
    chk("R9 irq suppressed", irq, 0);
    chk("R10 pfd toggled", pfd_out, exp_tog);
    pfd_en = 0;
    @(negedge clk);
    chk("R10 pfd disabled", pfd_out, 0);
    pfd_en = 1;

    // R6 event mode rising
    wr(1, 16'h0000);
    wr(0, 16'h0010);
    wr(1, 16'h0050);
    tick_sys = 1;
    for (int i = 0; i < 5; i++) begin pulse(1, 4); pulse(0, 4); end
    pulse(1, 4);
    chk("R6 rising edges", count, 16'h0016);
    pulse(0, 4);
    chk("R6 fall ignored", count, 16'h0016);
    // R6 event mode falling
    wr(1, 16'h0000);
    wr(0, 16'h0010);
    wr(1, 16'h0058);
    for (int i = 0; i < 5; i++) begin pulse(1, 4); pulse(0, 4); end
    pulse(1, 4);
    chk("R6 falling edges", count, 16'h0015);
    pulse(0, 4);
    chk("R6 last fall", count, 16'h0016);
    chk("R11 event run kept", ctrl[4], 1);

    // R7 pulse mode
    wr(1, 16'h0000);
    wr(0, 16'h0100);
    wr(1, 16'h00F0);
    pulse(0, 4);
    pulse(1, 7); pulse(0, 5);
    chk("R7 width", count, 16'h0107);
    chk("R7 run cleared", ctrl, 8'hE0);
    pulse(1, 4); pulse(0, 5);
    chk("R7 second pulse ignored", count, 16'h0107);
    wr(1, 16'h00F0);
    pulse(1, 3); pulse(0, 5);
    chk("R7 rearmed", count, 16'h010A);
    pulse(1, 5);
    wr(1, 16'h00F8);
    pulse(0, 4); pulse(1, 5);
    chk("R7 low pulse", count, 16'h010E);
    chk("R7 run cleared low", ctrl, 8'hE8);
    tick_sys = 0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule